// File: doc/BRIEF.md
# Set-Associative Page Translation Unit

This block turns a virtual address into a physical address with a page table that is split into sets. The virtual address holds three fields. From most to least significant they are a tag, a set index and a page offset. The index picks one set directly. Every way of that set then compares its stored tag with the tag of the request, and all the ways do this at the same time. When a valid way matches, its physical page number is placed in front of the unchanged offset. When no valid way matches, the block reports a page fault and does nothing more about it.

A separate controller loads pages and chooses which entry to replace. It writes entries through a fill port by naming the set, the way, the tag and the physical page number. While it does so, the block tells it whether the entry being overwritten holds a modified page, so the controller knows that page must be written back first. Each entry carries a valid bit and a dirty bit. A write access that hits an entry sets that entry's dirty bit.

Top module: `xl_sa_xlate`

## Requirements
- R1: The virtual address `lk_va` is laid out as {tag, index, offset}, with the tag in the top TAG_W bits, the index in the next IDX_W bits and the offset in the low OFF_W bits. On a hit, `lk_pa` equals {stored physical page number, offset}, in the same cycle as the request.
- R2: The index selects exactly one of the 2^IDX_W sets. An entry with a matching tag in any other set never produces a hit.
- R3: A way hits only if its valid bit is set and its stored tag equals the request tag. At most one way of a set hits. `lk_hit` is 1 when `lk_en` is 1 and some way hits.
- R4: When `lk_en` is 1 and no way hits, `lk_fault` is 1, `lk_hit` is 0 and `lk_pa` is all zeros. When `lk_en` is 0, both `lk_hit` and `lk_fault` are 0.
- R5: A synchronous active-high `rst` clears every valid bit and every dirty bit, so every lookup faults until entries are filled.
- R6: When `fl_en` is 1 at a rising clock edge, the entry at (`fl_set`, `fl_way`) takes `fl_tag` and `fl_ppn` with valid=1 and dirty=0. A lookup can see the new entry from the next cycle onward.
- R7: A lookup with `lk_en`=1 and `lk_wr`=1 that hits sets the dirty bit of the entry it hit at the clock edge. A read hit (`lk_wr`=0) leaves the dirty bit unchanged.
- R8: While `fl_en` is 1, `fl_victim_dirty` is 1 exactly when the entry currently at (`fl_set`, `fl_way`) is both valid and dirty. While `fl_en` is 0, it is 0.
- R9: If a fill and a lookup target the same entry in the same cycle, the lookup sees the contents from before the fill. If that lookup is a write hit, the fill takes priority and the entry ends with dirty=0.
- R10: A fill changes only the named way of the named set. The other ways of that set and all other sets keep their entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request present |
| lk_wr | input | 1 | The lookup is a write access |
| lk_va | input | TAG_W+IDX_W+OFF_W | Virtual address {tag, index, offset} |
| lk_hit | output | 1 | Translation found |
| lk_fault | output | 1 | Page fault: no valid matching way |
| lk_pa | output | PPN_W+OFF_W | Physical address {ppn, offset}, zero when there is no hit |
| fl_en | input | 1 | Write an entry |
| fl_set | input | IDX_W | Set to write |
| fl_way | input | max(1,log2 WAYS) | Way to write (the victim) |
| fl_tag | input | TAG_W | Tag to store |
| fl_ppn | input | PPN_W | Physical page number to store |
| fl_victim_dirty | output | 1 | The entry being replaced is valid and dirty |

## Verification
The assertions assume that the controller never gives one tag two valid ways in the same set. If it did, more than one way could match and the check that at most one way hits would not hold. They also assume `fl_way` is always below WAYS. The bench's random fills keep to both rules. When the tag being filled already has a valid way in the chosen set, the bench redirects the fill to that way, and it only draws way numbers below WAYS. Directed cycles deliberately drive a fill and a write hit to the same entry, to exercise the priority between them.

// File: rtl/xl_pkg.sv
package xl_pkg;
  // Width of a way-select field for a given way count (at least one bit).
  function automatic int unsigned xl_way_bits(int unsigned ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction

  // Position of the lowest set bit of a one-hot (or zero) vector.
  function automatic int unsigned xl_low_bit(logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/xl_va_split.sv
module xl_va_split #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 3,
  parameter int OFF_W = 4,
  localparam int VA_W = TAG_W + IDX_W + OFF_W
) (
  input  logic [VA_W-1:0]  va,
  output logic [TAG_W-1:0] tag,
  output logic [IDX_W-1:0] idx,
  output logic [OFF_W-1:0] off
);
  assign tag = va[VA_W-1 -: TAG_W];
  assign idx = va[OFF_W +: IDX_W];
  assign off = va[OFF_W-1:0];
endmodule

// File: rtl/xl_way_bank.sv
module xl_way_bank #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 3,
  parameter int PPN_W = 6,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PPN_W-1:0] rd_ppn,
  output logic             rd_vld,
  input  logic [IDX_W-1:0] vic_idx,
  output logic             vic_vld,
  output logic             vic_dty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [PPN_W-1:0] ppn_mem [SETS];
  logic [SETS-1:0]  vld_q;
  logic [SETS-1:0]  dty_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      ppn_mem[wr_idx] <= wr_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
    end else begin
      if (mark_en) dty_q[mark_idx] <= 1'b1;
      if (wr_en) begin
        vld_q[wr_idx] <= 1'b1;
        dty_q[wr_idx] <= 1'b0;
      end
    end
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_ppn  = ppn_mem[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign vic_vld = vld_q[vic_idx];
  assign vic_dty = dty_q[vic_idx];

  // R6
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)] && !dty_q[$past(wr_idx)]);

  // R7
  mark_sets_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_en && !(wr_en && wr_idx == mark_idx)) |=> dty_q[$past(mark_idx)]);

  // R9
  fill_beats_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_en && wr_en && wr_idx == mark_idx) |=> !dty_q[$past(mark_idx)]);
endmodule

// File: rtl/xl_way_match.sv
module xl_way_match #(
  parameter int TAG_W = 8,
  parameter int PPN_W = 6,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] way_tag [WAYS],
  input  logic [PPN_W-1:0] way_ppn [WAYS],
  input  logic [WAYS-1:0]  way_vld,
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_vld[w] && (way_tag[w] == req_tag);
  end

  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_ppn = hit_ppn | ({PPN_W{hit_vec[w]}} & way_ppn[w]);
    end
  end

  assign hit = |hit_vec;

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/xl_sa_xlate.sv
module xl_sa_xlate #(
  parameter int TAG_W = 8,
  parameter int IDX_W = 3,
  parameter int OFF_W = 4,
  parameter int PPN_W = 6,
  parameter int WAYS  = 4,
  localparam int VA_W  = TAG_W + IDX_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int WAY_W = xl_pkg::xl_way_bits(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic             lk_wr,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_pa,
  input  logic             fl_en,
  input  logic [IDX_W-1:0] fl_set,
  input  logic [WAY_W-1:0] fl_way,
  input  logic [TAG_W-1:0] fl_tag,
  input  logic [PPN_W-1:0] fl_ppn,
  output logic             fl_victim_dirty
);
  logic [TAG_W-1:0] va_tag;
  logic [IDX_W-1:0] va_idx;
  logic [OFF_W-1:0] va_off;

  logic [TAG_W-1:0] way_tag [WAYS];
  logic [PPN_W-1:0] way_ppn [WAYS];
  logic [WAYS-1:0]  way_vld;
  logic [WAYS-1:0]  vic_vld;
  logic [WAYS-1:0]  vic_dty;
  logic [WAYS-1:0]  hit_vec;
  logic             any_hit;
  logic [PPN_W-1:0] hit_ppn;

  xl_va_split #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) split_i (
    .va(lk_va), .tag(va_tag), .idx(va_idx), .off(va_off)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic fill_here;
    assign fill_here = fl_en && (fl_way == WAY_W'(w));
    xl_way_bank #(.TAG_W(TAG_W), .IDX_W(IDX_W), .PPN_W(PPN_W)) bank_i (
      .clk(clk), .rst(rst),
      .rd_idx(va_idx), .rd_tag(way_tag[w]), .rd_ppn(way_ppn[w]), .rd_vld(way_vld[w]),
      .vic_idx(fl_set), .vic_vld(vic_vld[w]), .vic_dty(vic_dty[w]),
      .wr_en(fill_here), .wr_idx(fl_set), .wr_tag(fl_tag), .wr_ppn(fl_ppn),
      .mark_en(lk_en && lk_wr && hit_vec[w]), .mark_idx(va_idx)
    );
  end

  xl_way_match #(.TAG_W(TAG_W), .PPN_W(PPN_W), .WAYS(WAYS)) match_i (
    .clk(clk), .rst(rst), .req_tag(va_tag),
    .way_tag(way_tag), .way_ppn(way_ppn), .way_vld(way_vld),
    .hit_vec(hit_vec), .hit(any_hit), .hit_ppn(hit_ppn)
  );

  always_comb begin
    lk_hit   = lk_en && any_hit;
    lk_fault = lk_en && !any_hit;
    lk_pa    = lk_hit ? {hit_ppn, va_off} : '0;
  end

  assign fl_victim_dirty = fl_en && vic_vld[fl_way] && vic_dty[fl_way];

  // R4
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_fault));

  // R4
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> lk_pa == '0);

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);

  // R5
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !lk_hit);

  // R8
  victim_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fl_en |-> !fl_victim_dirty);
endmodule

// File: tb/xl_sa_xlate_tb_top.sv
module xl_sa_xlate_tb_top;
  localparam int TAG_W = 8, IDX_W = 3, OFF_W = 4, PPN_W = 6, WAYS = 4;
  localparam int SETS = 1 << IDX_W;
  localparam int VA_W = TAG_W + IDX_W + OFF_W;
  localparam int PA_W = PPN_W + OFF_W;
  localparam int WAY_W = 2;

  logic clk = 0, rst = 1;
  logic lk_en = 0, lk_wr = 0;
  logic [VA_W-1:0] lk_va = '0;
  logic lk_hit, lk_fault, fl_victim_dirty;
  logic [PA_W-1:0] lk_pa;
  logic fl_en = 0;
  logic [IDX_W-1:0] fl_set = '0;
  logic [WAY_W-1:0] fl_way = '0;
  logic [TAG_W-1:0] fl_tag = '0;
  logic [PPN_W-1:0] fl_ppn = '0;

  int checks = 0, fails = 0;
  bit m_vld [SETS][WAYS];
  bit m_dty [SETS][WAYS];
  int m_tag [SETS][WAYS];
  int m_ppn [SETS][WAYS];

  always #2 clk = ~clk;

  xl_sa_xlate #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst(rst), .lk_en(lk_en), .lk_wr(lk_wr), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_pa(lk_pa),
    .fl_en(fl_en), .fl_set(fl_set), .fl_way(fl_way), .fl_tag(fl_tag), .fl_ppn(fl_ppn),
    .fl_victim_dirty(fl_victim_dirty)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_vld[s][w] = 0; m_dty[s][w] = 0;
      end
  endtask

  // One cycle: drive inputs, compare with model, advance model at the edge.
  task automatic step(string req, bit en, bit wr, int tag, int idx, int off,
                      bit fen, int fset, int fway, int ftag, int fppn);
    int hw, ehit, epa, evd;
    lk_en = en; lk_wr = wr;
    lk_va = VA_W'((tag << (IDX_W + OFF_W)) | (idx << OFF_W) | off);
    fl_en = fen; fl_set = IDX_W'(fset); fl_way = WAY_W'(fway);
    fl_tag = TAG_W'(ftag); fl_ppn = PPN_W'(fppn);
    #1;
    hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[idx][w] && m_tag[idx][w] == tag) hw = w;
    ehit = (en && hw >= 0) ? 1 : 0;
    epa  = ehit ? ((m_ppn[idx][hw] << OFF_W) | off) : 0;
    evd  = (fen && m_vld[fset][fway] && m_dty[fset][fway]) ? 1 : 0;
    check(req, "lk_hit", int'(lk_hit), ehit);
    check(req, "lk_fault", int'(lk_fault), (en && hw < 0) ? 1 : 0);
    check(req, "lk_pa", int'(lk_pa), epa);
    check(req, "fl_victim_dirty", int'(fl_victim_dirty), evd);
    @(posedge clk);
    if (ehit && wr) m_dty[idx][hw] = 1;
    if (fen) begin
      m_vld[fset][fway] = 1; m_dty[fset][fway] = 0;
      m_tag[fset][fway] = ftag; m_ppn[fset][fway] = fppn;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R5: every lookup faults after reset
    step("R5", 1, 0, 8'h5A, 2, 3, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
    // R6 fill with same-cycle lookup of that entry: R9 old contents (fault)
    step("R9", 1, 0, 8'h5A, 2, 3, 1, 2, 1, 8'h5A, 6'h2B);
    // R1 R3 read hit
    step("R1", 1, 0, 8'h5A, 2, 4'hC, 0, 0, 0, 0, 0);
    // R2 same tag in other set faults
    step("R2", 1, 0, 8'h5A, 3, 4'hC, 0, 0, 0, 0, 0);
    // R4 no request: no hit, no fault
    step("R4", 0, 0, 8'h5A, 2, 1, 0, 0, 0, 0, 0);
    // R6 fill other way of set 2
    step("R6", 0, 0, 0, 0, 0, 1, 2, 0, 8'h11, 6'h05);
    step("R6", 1, 0, 8'h11, 2, 7, 0, 0, 0, 0, 0);
    // R7 read hit leaves dirty clear: observe via R8 victim flag on a refill
    step("R7", 1, 0, 8'h11, 2, 7, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 2, 0, 8'h11, 6'h05);
    // R7 write hit sets dirty
    step("R7", 1, 1, 8'h5A, 2, 0, 0, 0, 0, 0, 0);
    // R8 replace dirty way 1 with new tag
    step("R8", 0, 0, 0, 0, 0, 1, 2, 1, 8'h77, 6'h3F);
    // R10 old tag gone, way 0 untouched, new tag hits
    step("R10", 1, 0, 8'h5A, 2, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 8'h11, 2, 9, 0, 0, 0, 0, 0);
    step("R10", 1, 0, 8'h77, 2, 4'hF, 0, 0, 0, 0, 0);
    // R9 write hit and fill to the same entry together: fill wins, dirty 0
    step("R9", 1, 1, 8'h77, 2, 1, 1, 2, 1, 8'h77, 6'h10);
    step("R9", 0, 0, 0, 0, 0, 1, 2, 1, 8'h77, 6'h10);
    // R8 victim flag on a never-filled entry
    step("R8", 0, 0, 0, 0, 0, 1, 5, 3, 8'h22, 6'h01);
    // R3 random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int tg, ix, fs, fw, ft;
      tg = $urandom_range(0, 5); ix = $urandom_range(0, SETS - 1);
      fs = $urandom_range(0, SETS - 1); fw = $urandom_range(0, WAYS - 1);
      ft = $urandom_range(0, 5);
      for (int w = 0; w < WAYS; w++)
        if (m_vld[fs][w] && m_tag[fs][w] == ft) fw = w;
      step("R3", $urandom_range(0, 3) != 0, $urandom_range(0, 1), tg, ix,
           $urandom_range(0, 15), $urandom_range(0, 3) == 0, fs, fw, ft,
           $urandom_range(0, 63));
    end
    // R5 reset again clears everything
    rst = 1; @(negedge clk); rst = 0; model_reset();
    step("R5", 1, 0, 8'h11, 2, 0, 1, 2, 0, 8'h01, 6'h01);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule